// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

The arbiter collects one request line from each of several peripherals and presents a single interrupt line to the processor. While no service is in progress, the interrupt is high whenever any request is pending. When the processor answers with its interrupt-acknowledge, the arbiter picks one requester and raises that peripheral's own acknowledge line. That peripheral then drives its interrupt vector onto the shared data bus. The peripherals, the vectors and the bus belong to the surrounding system.

Two priority schemes are available, selected by a mode input. In fixed mode every source has a permanent rank. In rotating mode the search starts just after the source served last, so the source just served drops to the lowest rank and service is spread across requesters. The choice is frozen while a service is in progress. A service-done pulse from the processor ends the handshake. Only then can the interrupt line rise again.

Top module: `irq_prio_arb`

## Requirements
- R1: While no per-source acknowledge is high, `irq` equals the OR of all `req` bits. While any acknowledge is high, `irq` is low.
- R2: `dev_ack` rises only on the clock edge at which `int_ack` is sampled high with no service in progress and at least one request pending. It then carries exactly one bit, and that bit belongs to a source that was requesting. `int_ack` sampled with no pending request leaves `dev_ack` at zero.
- R3: With `rr_mode` = 0 (fixed), the lowest-numbered requesting source is acknowledged: source 0 has the highest rank and source N-1 the lowest.
- R4: With `rr_mode` = 1 (rotating), the search begins at the source after the last-served pointer, ascending and wrapping modulo N. After reset the pointer is N-1, so source 0 ranks highest.
- R5: When a service ends with `rr_mode` = 1, the pointer takes the served source, which therefore ranks lowest next. A service that ends with `rr_mode` = 0 leaves the pointer unchanged.
- R6: Once `dev_ack` is set, neither changes to `req` nor further `int_ack` pulses alter it until the service ends.
- R7: `svc_done` sampled high during a service clears `dev_ack` on that edge. `irq` follows the requests again from that edge on. `svc_done` with no service in progress has no effect.
- R8: During and directly after reset, `dev_ack` is zero and the rotating pointer is N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| req | input | N_SRC | One request line per peripheral |
| int_ack | input | 1 | Interrupt-acknowledge from the processor |
| svc_done | input | 1 | End of service routine; completes the handshake |
| irq | output | 1 | Interrupt to the processor |
| dev_ack | output | N_SRC | One-hot acknowledge to the chosen peripheral |

## Verification
The bench drives a rotating sequence with all sources requesting and checks that service walks 0, 1, 2, 3 and wraps. A pointer that never advanced, or one that advanced during fixed-mode services, would repeat a source or skip one. It changes the requests and pulses `int_ack` again in the middle of a service. An arbiter that re-picked live would move `dev_ack` or raise `irq` before the service ended. It also applies `int_ack` with no requests and `svc_done` with no service in progress. A design that mishandled these would grant a phantom source or disturb the idle state.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SERVE = 1'b1} irqa_state_e;
endpackage

// File: rtl/irqa_pick.sv
// Combinational winner selection for fixed or rotating priority.
module irqa_pick #(
  parameter int N_SRC = 4,
  localparam int W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  input  logic             rr_mode,
  input  logic [W-1:0]     last,
  output logic [W-1:0]     win,
  output logic             any
);
  logic [W-1:0] win_fix, win_rot;
  logic         hit_fix, hit_rot;

  always_comb begin
    win_fix = '0;
    hit_fix = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (!hit_fix && req[i]) begin
        hit_fix = 1'b1;
        win_fix = W'(i);
      end
    end
  end

  always_comb begin
    int idx;
    win_rot = '0;
    hit_rot = 1'b0;
    idx     = 0;
    for (int k = 1; k <= N_SRC; k++) begin
      idx = (int'(last) + k) % N_SRC;
      if (!hit_rot && req[idx]) begin
        hit_rot = 1'b1;
        win_rot = W'(idx);
      end
    end
  end

  assign any = |req;
  assign win = rr_mode ? win_rot : win_fix;
endmodule

// File: rtl/irqa_rot_ptr.sv
// Last-served pointer for rotating priority.
module irqa_rot_ptr #(
  parameter int N_SRC = 4,
  localparam int W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] last
);
  logic [W-1:0] last_q, last_d;

  always_comb begin
    last_d = last_q;
    if (upd_en) last_d = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= W'(N_SRC - 1);
    else        last_q <= last_d;
  end

  assign last = last_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_SRC = 4,
  localparam int W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode,
  input  logic [N_SRC-1:0] req,
  input  logic             int_ack,
  input  logic             svc_done,
  output logic             irq,
  output logic [N_SRC-1:0] dev_ack
);
  import irqa_pkg::*;

  irqa_state_e      state_q, state_d;
  logic [W-1:0]     win_q, win_d, pick, last;
  logic [N_SRC-1:0] ack_q, ack_d;
  logic             any, ptr_upd, grant_ld;

  irqa_pick #(.N_SRC(N_SRC)) u_pick (
    .req(req), .rr_mode(rr_mode), .last(last), .win(pick), .any(any)
  );

  irqa_rot_ptr #(.N_SRC(N_SRC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .upd_en(ptr_upd), .upd_val(win_q), .last(last)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    win_d    = win_q;
    ack_d    = ack_q;
    ptr_upd  = 1'b0;
    grant_ld = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (int_ack && any) begin
          grant_ld = 1'b1;
          state_d  = ST_SERVE;
          win_d    = pick;
          ack_d    = {{(N_SRC-1){1'b0}}, 1'b1} << pick;
        end
      end
      ST_SERVE: begin
        if (svc_done) begin
          state_d = ST_IDLE;
          ack_d   = '0;
          ptr_upd = rr_mode;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      ack_q   <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      if (grant_ld) win_q <= win_d;
    end
  end

  assign irq     = (state_q == ST_IDLE) && any;
  assign dev_ack = ack_q;
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req,
  input logic             int_ack,
  input logic             svc_done,
  input logic             irq,
  input logic [N_SRC-1:0] dev_ack
);
  AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack == '0) |-> (irq == (|req)));                                  // R1
  AST_IRQ_LOW_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |-> !irq);                                                  // R1
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));                                                    // R2
  AST_ACK_NEEDS_INTA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dev_ack) |-> $past(int_ack));                                   // R2
  AST_ACK_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dev_ack) |-> (($past(req) & dev_ack) != '0));                   // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_ack) && !svc_done) |=> $stable(dev_ack));                       // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_ack) && svc_done) |=> (dev_ack == '0));                         // R7
endmodule

bind irq_prio_arb irqa_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .int_ack(int_ack),
  .svc_done(svc_done), .irq(irq), .dev_ack(dev_ack)
);

// File: tb/tb_irq_prio_arb.sv
`timescale 1ns/1ps
module tb_irq_prio_arb;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rr_mode;
  logic [N-1:0] req;
  logic         int_ack;
  logic         svc_done;
  logic         irq;
  logic [N-1:0] dev_ack;

  int total = 0;
  int bad   = 0;
  int last_m = N - 1;  // bench model of the last-served pointer

  always #2 clk = ~clk;  // 250 MHz

  irq_prio_arb #(.N_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req),
    .int_ack(int_ack), .svc_done(svc_done), .irq(irq), .dev_ack(dev_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [N-1:0] r, input logic m, input int lst);
    for (int k = 0; k < N; k++) begin
      int i;
      i = m ? (lst + 1 + k) % N : k;
      if (r[i]) return i;
    end
    return -1;
  endfunction

  // advance to a point just after a falling edge
  task automatic step();
    @(negedge clk); #0.5;
  endtask

  // full handshake: requests, int_ack, check grant, done, check release
  task automatic service(input logic [N-1:0] r, input logic m, input string tag);
    int exp;
    rr_mode = m; req = r;
    step();
    chk({tag, " R1 irq with pending request"}, irq, 1'b1);
    exp = model_pick(r, m, last_m);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk({tag, m ? " R4 rotating winner" : " R3 fixed winner"}, dev_ack, 32'(1) << exp);
    chk({tag, " R1 irq low in service"}, irq, 1'b0);
    svc_done = 1'b1;
    step();
    svc_done = 1'b0;
    chk({tag, " R7 done clears ack"}, dev_ack, 0);
    if (m) last_m = exp;  // R5
    req = '0;
  endtask

  task automatic t_reset();
    chk("R8 ack zero in reset", dev_ack, 0);
    step();
    chk("R8 ack zero after reset", dev_ack, 0);
    chk("R1 irq low with no request", irq, 1'b0);
  endtask

  task automatic t_inta_no_req();
    req = '0; int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    step();
    chk("R2 int_ack without request gives no ack", dev_ack, 0);
  endtask

  task automatic t_fixed();
    service(4'b1010, 1'b0, "fix_a");
    service(4'b1100, 1'b0, "fix_b");
    service(4'b1000, 1'b0, "fix_c");
    service(4'b0110, 1'b0, "fix_d");
    service(4'b0110, 1'b0, "fix_e");  // R3 same winner twice
  endtask

  task automatic t_rotate();
    // R5: fixed services above left the pointer at N-1, so source 0 comes first
    for (int n = 0; n < 5; n++) service(4'b1111, 1'b1, "rot_all");
    service(4'b1001, 1'b1, "rot_pair1");
    service(4'b1001, 1'b1, "rot_pair2");
    service(4'b0010, 1'b1, "rot_single");
  endtask

  task automatic t_latch();
    rr_mode = 1'b0; req = 4'b0100;
    step();
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk("R6 grant to source 2", dev_ack, 4'b0100);
    req = 4'b0001;
    step(); step();
    chk("R6 ack holds after request change", dev_ack, 4'b0100);
    chk("R1 irq low while serving", irq, 1'b0);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk("R6 ack holds after second int_ack", dev_ack, 4'b0100);
    svc_done = 1'b1;
    step();
    svc_done = 1'b0;
    chk("R7 ack cleared", dev_ack, 0);
    chk("R7 irq re-evaluated after done", irq, 1'b1);
    req = '0;
    svc_done = 1'b1;
    step();
    svc_done = 1'b0;
    step();
    chk("R7 done while idle has no effect", dev_ack, 0);
    chk("R7 irq stays low while idle", irq, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; rr_mode = 1'b0; req = '0; int_ack = 1'b0; svc_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_inta_no_req();
    t_fixed();
    t_rotate();
    t_latch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule